// File: doc/BRIEF.md
# Block-Mode Serial Configuration Slave

This block is a two-wire serial slave that holds the configuration bytes of a clock generator. A host changes the settings with one block write and reads all of them back with one block read. There is no random access. A write always starts at byte 0 and moves upward one byte at a time. A read always returns a byte count first, then every byte from index 0 upward.

Both bus lines first pass through a two-flop synchronizer and a glitch filter. A small edge detector then turns them into four events: start, stop, clock rise and clock fall. A controller built from twelve named states handles the protocol:

- `ST_IDLE` waits for a start.
- `ST_ADDR` shifts in the address. A match leads to `ST_ADDR_ACK`. A mismatch leads to `ST_HOLD`.
- On a write, `ST_ADDR_ACK` leads to `ST_CMD`. A read goes straight to `ST_RDATA`.
- `ST_CMD` leads to `ST_CMD_ACK`, which leads to `ST_CNT`, then `ST_CNT_ACK`, then `ST_WDATA`.
- `ST_WDATA` leads to `ST_WDATA_ACK` and back again for each stored byte. It goes to `ST_HOLD` once the writable bytes are used up.
- `ST_RDATA` leads to `ST_RACK`. From `ST_RACK` the controller returns to `ST_RDATA` if the host acknowledged and items remain. Otherwise it goes to `ST_HOLD`.
- `ST_HOLD` waits for the next start or stop.
- A start in any state jumps to `ST_ADDR`. A stop in any state returns to `ST_IDLE`.

The stored bytes go out on a parallel bus. Two fields of the read data are taken live from input pins: the frequency-strap pins and the stop/mode status pins.

Top module: `cfg_serial_slave`

## Requirements
- R1: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. After any other address, the slave leaves SDA released for the rest of the transaction, and nothing it carries changes the registers.
- R2: In a write, the two bytes that follow the address are acknowledged and discarded. Their values never change which register the data lands in.
- R3: Write data bytes are acknowledged and stored at indices 0, 1, 2 and upward, in arrival order. Every write transaction starts again at index 0.
- R4: Only indices 0 to 6 are writable. A data byte that arrives after seven stored bytes is not acknowledged and is not stored. Index 7 always reads as the fixed identifier 0x25.
- R5: A read returns the count value 8 first, then bytes 0 to 7, each sent MSB first.
- R6: After reset, byte 0 is 0x00, bytes 1 to 5 are 0xFF and byte 6 is 0x00. `cfg_q[8k+7:8k]` carries byte k.
- R7: On read, bits 7:4 of byte 4 return the inverse of `strap_fs[3:0]`, and bits 5:1 of byte 6 return `pin_status[4:0]`. All other bits return the stored value.
- R8: A byte cut off by a stop before its eighth bit is not stored. Bytes completed earlier in the same transaction keep their new values.
- R9: A start in the middle of a byte abandons the transfer. The slave then decodes the next byte as a fresh address.
- R10: After the host NACKs a read byte, or after the last item (index 8) has been sent, the slave keeps SDA released until the next start or stop. Further clocks then read as 0xFF.
- R11: A pulse on SCL shorter than `FILT_LEN` system clocks is ignored and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_out | output | 1 | Value driven when the driver is enabled (always low) |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| strap_fs | input | 4 | Latched frequency-strap pin levels for readback |
| pin_status | input | 5 | Stop and mode pin levels for readback |
| cfg_q | output | 56 | Stored bytes 0 to 6, byte k at bits 8k+7:8k |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:

- **Eighth data byte of a write.** A slave that wrapped the index or overran it would acknowledge the byte and corrupt byte 0, or lose the identifier.
- **Transaction cut inside a byte, by a stop or by a repeated start.** A design that committed on every bit, or kept its index across a start, would leave a half-shifted value in a register, or fail to acknowledge the new read address.
- **Command and count bytes varied.** Values that leaked into the index would shift where the data lands.
- **Read past the last item, and read after a NACK.** A slave that failed to release SDA would return something other than all ones.
- **A one-cycle SCL pulse inside a data byte.** An unfiltered slave would count it as an extra bit and store a shifted value.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_CNT,
        ST_CNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_HOLD
    } bus_state_t;

endpackage

// File: rtl/line_filter.sv
module line_filter #(
    parameter int STABLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            dout <= 1'b1;
            cnt  <= '0;
        end else begin
            s1 <= din;
            s2 <= s1;
            if (s2 == dout) begin
                cnt <= '0;
            end else if (cnt == CW'(STABLE_CYC - 1)) begin
                dout <= s2;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // the filtered level only ever moves to the synchronized level
    assert_filter_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> (dout == $past(s2)));

endmodule

// File: rtl/bus_events.sv
module bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start_ev,
    output logic stop_ev,
    output logic rise_ev,
    output logic fall_ev
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    always_comb begin
        start_ev = scl && scl_d && sda_d && !sda;
        stop_ev  = scl && scl_d && !sda_d && sda;
        rise_ev  = scl && !scl_d;
        fall_ev  = !scl && scl_d;
    end

    assert_events_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_ev, stop_ev, rise_ev, fall_ev}));

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
    parameter int         NUM_BYTES = 8,
    parameter int         NUM_WR    = 7,
    parameter logic [7:0] ID_VALUE  = 8'h25,
    parameter int         FS_BYTE   = 4,
    parameter int         STAT_BYTE = 6,
    parameter int         FS_W      = 4,
    parameter int         STAT_W    = 5,
    localparam int        IDX_W     = $clog2(NUM_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    input  logic [FS_W-1:0]       strap_fs,
    input  logic [STAT_W-1:0]     pin_status,
    output logic [NUM_WR*8-1:0]   cfg_q
);
    logic [7:0] rd_arr [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        if (g < NUM_WR) begin : g_rw
            localparam logic [7:0] DEF = (g == 0 || g == NUM_WR - 1) ? 8'h00 : 8'hFF;
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= DEF;
                else if (wr_en && wr_idx == IDX_W'(g))
                    q <= wr_data;
            end
            assign cfg_q[g*8 +: 8] = q;
            if (g == FS_BYTE) begin : g_fs
                assign rd_arr[g] = {~strap_fs, q[7-FS_W:0]};
            end else if (g == STAT_BYTE) begin : g_st
                assign rd_arr[g] = {q[7:STAT_W+1], pin_status, q[0]};
            end else begin : g_plain
                assign rd_arr[g] = q;
            end
        end else begin : g_ro
            assign rd_arr[g] = ID_VALUE;
        end
    end

    assign rd_data = rd_arr[rd_idx];

    assert_wr_index_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(NUM_WR)));
    assert_hold_without_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7 = 7'h69,
    parameter int         FILT_LEN  = 3,
    parameter int         NUM_BYTES = 8,
    parameter int         NUM_WR    = 7,
    parameter logic [7:0] ID_VALUE  = 8'h25
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                sda_out,
    output logic                sda_oe,
    input  logic [3:0]          strap_fs,
    input  logic [4:0]          pin_status,
    output logic [NUM_WR*8-1:0] cfg_q
);
    localparam int IDX_W = $clog2(NUM_BYTES);
    localparam int CNT_W = $clog2(NUM_BYTES + 2);

    logic [1:0] raw_lines, filt_lines;
    assign raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        line_filter #(.STABLE_CYC(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    logic scl_f, sda_f;
    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    logic start_ev, stop_ev, rise_ev, fall_ev;
    bus_events u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (scl_f),
        .sda     (sda_f),
        .start_ev(start_ev),
        .stop_ev (stop_ev),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    bus_state_t       state, state_nx;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg, txsh;
    logic [CNT_W-1:0] ridx, widx;
    logic             ack_ok;
    logic             byte_done, rx_state, ack_state, wr_room, rd_more;
    logic             wr_en;
    logic [7:0]       rd_data;

    always_comb begin
        byte_done = fall_ev && (bitcnt == 4'd8);
        rx_state  = (state == ST_ADDR) || (state == ST_CMD) ||
                    (state == ST_CNT)  || (state == ST_WDATA);
        ack_state = (state == ST_ADDR_ACK) || (state == ST_CMD_ACK) ||
                    (state == ST_CNT_ACK)  || (state == ST_WDATA_ACK);
        wr_room   = widx < CNT_W'(NUM_WR);
        rd_more   = ridx < CNT_W'(NUM_BYTES);
        wr_en     = (state == ST_WDATA) && byte_done && wr_room && !start_ev && !stop_ev;
    end

    cfg_regfile #(
        .NUM_BYTES(NUM_BYTES),
        .NUM_WR   (NUM_WR),
        .ID_VALUE (ID_VALUE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (widx[IDX_W-1:0]),
        .wr_data   (shreg),
        .rd_idx    (ridx[IDX_W-1:0]),
        .rd_data   (rd_data),
        .strap_fs  (strap_fs),
        .pin_status(pin_status),
        .cfg_q     (cfg_q)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_ev) begin
            state_nx = ST_ADDR;
        end else if (stop_ev) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_done)
                                  state_nx = (shreg[7:1] == DEV_ADDR7) ? ST_ADDR_ACK : ST_HOLD;
                ST_ADDR_ACK:  if (fall_ev) state_nx = shreg[0] ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_done) state_nx = ST_CMD_ACK;
                ST_CMD_ACK:   if (fall_ev) state_nx = ST_CNT;
                ST_CNT:       if (byte_done) state_nx = ST_CNT_ACK;
                ST_CNT_ACK:   if (fall_ev) state_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = wr_room ? ST_WDATA_ACK : ST_HOLD;
                ST_WDATA_ACK: if (fall_ev) state_nx = ST_WDATA;
                ST_RDATA:     if (fall_ev && bitcnt == 4'd7) state_nx = ST_RACK;
                ST_RACK:      if (fall_ev) state_nx = (ack_ok && rd_more) ? ST_RDATA : ST_HOLD;
                ST_HOLD:      state_nx = ST_HOLD;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // shift, count and index datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            txsh   <= 8'hFF;
            ridx   <= '0;
            widx   <= '0;
            ack_ok <= 1'b0;
        end else if (start_ev) begin
            bitcnt <= '0;
            ridx   <= '0;
            widx   <= '0;
            txsh   <= 8'hFF;
        end else if (!stop_ev) begin
            if (rx_state && rise_ev && bitcnt < 4'd8) begin
                shreg  <= {shreg[6:0], sda_f};
                bitcnt <= bitcnt + 4'd1;
            end
            if (ack_state && fall_ev)
                bitcnt <= '0;
            if (wr_en)
                widx <= widx + 1'b1;
            if (state == ST_ADDR_ACK && fall_ev && shreg[0])
                txsh <= 8'(NUM_BYTES);
            if (state == ST_RDATA && fall_ev) begin
                txsh   <= {txsh[6:0], 1'b1};
                bitcnt <= bitcnt + 4'd1;
            end
            if (state == ST_RACK && rise_ev)
                ack_ok <= !sda_f;
            if (state == ST_RACK && fall_ev) begin
                bitcnt <= '0;
                if (ack_ok && rd_more) begin
                    ridx <= ridx + 1'b1;
                    txsh <= rd_data;
                end else begin
                    txsh <= 8'hFF;
                end
            end
        end
    end

    // line driver
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_oe <= 1'b0;
        else        sda_oe <= ack_state || (state == ST_RDATA && !txsh[7]);
    end

    assign sda_out = 1'b0;

    assert_start_aborts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR));
    assert_hold_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_HOLD) |-> !sda_oe);
    assert_idle_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> !sda_oe);

endmodule

// File: tb/cfg_serial_slave_test.sv
module cfg_serial_slave_test;

    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scl_host, sda_host;
    logic        sda_line, sda_out, sda_oe;
    logic [3:0]  strap;
    logic [4:0]  status;
    logic [55:0] cfg_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] exp_q [7];
    logic [7:0] wbuf [10];
    logic [7:0] rbuf [12];

    always #10 clk = ~clk;

    assign sda_line = sda_host & ~sda_oe;

    cfg_serial_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_host),
        .sda_in    (sda_line),
        .sda_out   (sda_out),
        .sda_oe    (sda_oe),
        .strap_fs  (strap),
        .pin_status(status),
        .cfg_q     (cfg_q)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_host = 1'b1; wq();
        scl_host = 1'b1; wq();
        sda_host = 1'b0; wq();
        scl_host = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_host = 1'b0; wq();
        scl_host = 1'b1; wq();
        sda_host = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b, input bit glitch, output logic seen);
        sda_host = b;
        if (glitch) begin
            repeat (4) @(negedge clk);
            scl_host = 1'b1;
            @(negedge clk);
            scl_host = 1'b0;
            repeat (Q - 5) @(negedge clk);
        end else begin
            wq();
        end
        scl_host = 1'b1; wq();
        seen = sda_line; wq();
        scl_host = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, input bit glitch, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) put_bit(v[i], glitch, s);
        put_bit(1'b1, 1'b0, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input bit host_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1, 1'b0, s);
            v[i] = s;
        end
        put_bit(host_ack ? 1'b0 : 1'b1, 1'b0, s);
        sda_host = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] cmd, input logic [7:0] cnt, input int n,
                            output logic [15:0] acks);
        logic a;
        acks = '0;
        bus_start();
        send_byte(8'hD2, 1'b0, a); acks[0] = a;
        send_byte(cmd, 1'b0, a);   acks[1] = a;
        send_byte(cnt, 1'b0, a);   acks[2] = a;
        for (int j = 0; j < n; j++) begin
            send_byte(wbuf[j], 1'b0, a);
            acks[3+j] = a;
            if (j < 7) exp_q[j] = wbuf[j];
        end
        bus_stop();
    endtask

    task automatic do_read(input int n, input bit last_ack, output logic addr_ack);
        bus_start();
        send_byte(8'hD3, 1'b0, addr_ack);
        for (int k = 0; k < n; k++) recv_byte((k < n - 1) || last_ack, rbuf[k]);
        bus_stop();
    endtask

    function automatic logic [7:0] exp_item(input int k);
        logic [7:0] v;
        if (k == 0) return 8'd8;
        if (k - 1 == 7) return 8'h25;
        v = exp_q[k-1];
        if (k - 1 == 4) v[7:4] = ~strap;
        if (k - 1 == 6) v[5:1] = status;
        return v;
    endfunction

    task automatic check_cfg(input string tag);
        for (int b = 0; b < 7; b++) check(tag, cfg_q[b*8 +: 8], exp_q[b]);
    endtask

    task automatic check_read(input string tag);
        logic a;
        do_read(9, 1'b0, a);
        check({tag, " addr ack"}, a, 1'b1);
        for (int k = 0; k < 9; k++) check(tag, rbuf[k], exp_item(k));
    endtask

    // length in [11:8], seed in [7:0]
    localparam logic [11:0] VEC [6] = '{
        {4'd7, 8'h5A}, {4'd1, 8'hC3}, {4'd3, 8'h00},
        {4'd7, 8'hFF}, {4'd5, 8'h96}, {4'd2, 8'h3E}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] acks;
        logic        a;
        logic [7:0]  v;
        rst_n    = 1'b0;
        scl_host = 1'b1;
        sda_host = 1'b1;
        strap    = 4'hA;
        status   = 5'h13;
        exp_q[0] = 8'h00;
        for (int b = 1; b < 6; b++) exp_q[b] = 8'hFF;
        exp_q[6] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R6 reset values and released line
        check_cfg("R6 reset value");
        check("R10 line released after reset", sda_oe, 1'b0);
        // R5 R7 R4 read of the reset image
        check_read("R5 R7 R4 read after reset");

        // table-driven write and read-back
        for (int i = 0; i < 6; i++) begin
            int         len;
            logic [7:0] seed;
            len    = int'(VEC[i][11:8]);
            seed   = VEC[i][7:0];
            strap  = seed[3:0] ^ 4'(i);
            status = seed[4:0];
            for (int j = 0; j < len; j++) wbuf[j] = 8'(seed + j * 37);
            do_write(~seed, seed, len, acks);
            check("R1 write address ack", acks[0], 1'b1);
            check("R2 command and count ack", acks[2:1], 2'b11);
            for (int j = 0; j < len; j++) check("R3 data ack", acks[3+j], 1'b1);
            check_cfg("R3 R2 stored in order from index 0");
            check_read("R5 R7 read-back");
        end

        // R1 foreign address: NACK, following bytes ignored
        bus_start();
        send_byte(8'hA0, 1'b0, a);
        check("R1 foreign address nack", a, 1'b0);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'h77, 1'b0, a);
        check("R1 data after foreign address nack", a, 1'b0);
        bus_stop();
        check_cfg("R1 registers untouched");

        // R4 eighth data byte refused, identifier intact
        for (int j = 0; j < 8; j++) wbuf[j] = 8'h10 + 8'(j);
        do_write(8'h00, 8'h08, 8, acks);
        for (int j = 0; j < 7; j++) check("R4 writable byte ack", acks[3+j], 1'b1);
        check("R4 eighth data byte nack", acks[10], 1'b0);
        check_cfg("R4 seven bytes stored, no wrap");
        check_read("R4 identifier read");

        // R8 stop inside a byte
        bus_start();
        send_byte(8'hD2, 1'b0, a);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'hE1, 1'b0, a); exp_q[0] = 8'hE1;
        send_byte(8'hE2, 1'b0, a); exp_q[1] = 8'hE2;
        put_bit(1'b0, 1'b0, a);
        put_bit(1'b1, 1'b0, a);
        put_bit(1'b0, 1'b0, a);
        bus_stop();
        check_cfg("R8 partial byte dropped");

        // R9 repeated start inside a write data byte, then a read
        bus_start();
        send_byte(8'hD2, 1'b0, a);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'h00, 1'b0, a);
        for (int i = 0; i < 4; i++) put_bit(1'b0, 1'b0, a);
        bus_start();
        send_byte(8'hD3, 1'b0, a);
        check("R9 address after abort ack", a, 1'b1);
        recv_byte(1'b1, v);
        check("R9 count after abort", v, 8'd8);
        recv_byte(1'b0, v);
        check("R9 byte 0 after abort", v, exp_item(1));
        bus_stop();
        check_cfg("R9 abort stores nothing");

        // R10 host NACK releases the line
        bus_start();
        send_byte(8'hD3, 1'b0, a);
        recv_byte(1'b1, v);
        recv_byte(1'b0, v);
        check("R10 byte before nack", v, exp_item(1));
        recv_byte(1'b0, v);
        check("R10 released after nack", v, 8'hFF);
        bus_stop();

        // R10 read past the last item
        do_read(10, 1'b0, a);
        for (int k = 0; k < 9; k++) check("R5 full read", rbuf[k], exp_item(k));
        check("R10 released after last item", rbuf[9], 8'hFF);

        // R11 one-cycle SCL pulses inside a data byte
        bus_start();
        send_byte(8'hD2, 1'b0, a);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'h6B, 1'b1, a);
        check("R11 glitched byte ack", a, 1'b1);
        exp_q[0] = 8'h6B;
        bus_stop();
        check_cfg("R11 glitches ignored");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule